// File: doc/BRIEF.md
# GPIO Pad Event Interrupt Controller

This block manages a group of general-purpose pads, 24 by default. Each pad has a 32-bit configuration word. The word selects the pad's function (GPIO or another mode), whether its output driver and input receiver are enabled, the level it drives, an input inversion, and how input changes become events. The pad inputs are synchronised first. Events are then detected per pad and recorded in a group interrupt status register and a group wake status register. Both status registers are write-one-to-clear. A per-pad enable bit qualifies each status register.

The block has two outputs. A single combined interrupt line rises when any enabled interrupt status bit is set. A wake line rises when any enabled wake status bit is set on a pad that is not routed to the system control interrupt. Software reaches every register through a flat word-addressed read/write port. Reads return data one cycle after the address is presented.

Top module: `padgrp_evt_ctrl`

## Requirements
- R1: After reset, every configuration word reads 0x0000_0300 (transmit-disable bit 8 and receive-disable bit 9 set). The interrupt status (0x100), interrupt enable (0x120), wake status (0x140) and wake enable (0x160) registers read 0. `pad_oe`, `pad_out`, `irq_o` and `wake_o` are 0.
- R2: Configuration word `i` sits at byte address 0x400 + 8*i. The writable fields are: output level bit 0, transmit-disable bit 8, receive-disable bit 9, mode bits 13:10, routing bits 20:17 (bit 19 routes to the system control interrupt), inversion bit 23, and event select bits 26:25. All other bits read 0. Bit 1 is read-only and reads the pad input after a two-flop synchroniser.
- R3: While a pad's mode field is 0, `pad_oe[i]` is the inverse of transmit-disable and `pad_out[i]` is bit 0. While the mode is non-zero, both are 0. Both outputs are registered.
- R4: Event select 0 is level mode. While the qualified input is 1, the pad's status bits are set on every cycle. With inversion (bit 23) set, a low input is the active level.
- R5: Event select 1 is single-edge mode. A 0-to-1 change of the input sets the status bits. With inversion set, a 1-to-0 change sets them instead, and a 0-to-1 change does not.
- R6: Event select 3 sets the status bits on both input transitions.
- R7: No event is recorded when event select is 2, when receive-disable is set, or when the mode field is non-zero.
- R8: Writing 1 to a bit of either status register clears that bit. Writing 0 leaves the bit unchanged.
- R9: If an event and a clear hit the same status bit in the same cycle, the bit stays set.
- R10: `irq_o` is 1 exactly when some interrupt status bit and its matching enable bit (pad number = bit number) are both 1. It follows one register stage later.
- R11: An event also sets the pad's wake status bit. `wake_o` is 1 when some pad has both wake status and wake enable set and has routing bit 19 clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_rdata | output | 32 | Read data for the address of the previous cycle |
| pad_in | input | 24 | Asynchronous pad inputs |
| pad_out | output | 24 | Pad drive levels |
| pad_oe | output | 24 | Pad output enables |
| irq_o | output | 1 | Combined interrupt |
| wake_o | output | 1 | Combined wake request |

## Verification
A stuck or mis-set status bit appears on `irq_o` or `wake_o` within two cycles of the enable being set. A read of the status register shows it one cycle after the address is presented. A wrong edge-history or inversion state shows as a status bit that appears or fails to appear about three cycles after a pad input changes. The directed scenarios therefore pair every input change with a read back of both status registers. A wrong configuration field appears at `pad_oe` and `pad_out` two cycles after the write.

// File: rtl/padgrp_pkg.sv
package padgrp_pkg;
  localparam int CFG_TXLVL  = 0;
  localparam int CFG_RXST   = 1;
  localparam int CFG_TXDIS  = 8;
  localparam int CFG_RXDIS  = 9;
  localparam int CFG_MODE_L = 10;
  localparam int CFG_SCI    = 19;
  localparam int CFG_INV    = 23;
  localparam int CFG_EVT_L  = 25;

  localparam logic [31:0] CFG_WMASK = 32'h069E_3F01;
  localparam logic [31:0] CFG_RST   = 32'h0000_0300;

  localparam int ADR_INT_STS = 'h100;
  localparam int ADR_INT_EN  = 'h120;
  localparam int ADR_WK_STS  = 'h140;
  localparam int ADR_WK_EN   = 'h160;
  localparam int ADR_CFG     = 'h400;
  localparam int CFG_PITCH   = 8;

  typedef enum logic [1:0] {
    EV_LEVEL = 2'd0,
    EV_EDGE  = 2'd1,
    EV_OFF   = 2'd2,
    EV_BOTH  = 2'd3
  } evsel_e;
endpackage

// File: rtl/padgrp_sync.sv
module padgrp_sync #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/padgrp_w1c.sv
module padgrp_w1c #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  input  logic [W-1:0] set_bits,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] sts_q;
  logic [W-1:0] clr_m;

  assign clr_m = clr_we ? clr_bits : '0;

  // set takes priority over clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) sts_q <= '0;
    else     sts_q <= (sts_q & ~clr_m) | set_bits;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/padgrp_pad.sv
module padgrp_pad
  import padgrp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        rx_sync,
  output logic [31:0] cfg_rd,
  output logic        evt_o,
  output logic        sci_o,
  output logic        gpio_o,
  output logic        pad_out_o,
  output logic        pad_oe_o
);
  logic [31:0] cfg_q;
  logic        prev_q;
  logic        gpio, rx_on, inv, cur, old, hit;
  evsel_e      evsel;

  always_ff @(posedge clk) begin
    if (rst)        cfg_q <= CFG_RST;
    else if (wr_en) cfg_q <= wdata & CFG_WMASK;
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= rx_sync;
  end

  assign gpio  = (cfg_q[CFG_MODE_L +: 4] == 4'd0);
  assign rx_on = gpio && !cfg_q[CFG_RXDIS];
  assign inv   = cfg_q[CFG_INV];
  assign cur   = rx_sync ^ inv;
  assign old   = prev_q ^ inv;
  assign evsel = evsel_e'(cfg_q[CFG_EVT_L +: 2]);

  always_comb begin
    unique case (evsel)
      EV_LEVEL: hit = cur;
      EV_EDGE:  hit = cur & ~old;
      EV_BOTH:  hit = cur ^ old;
      default:  hit = 1'b0;
    endcase
  end

  assign evt_o  = rx_on & hit;
  assign sci_o  = cfg_q[CFG_SCI];
  assign gpio_o = gpio;
  assign cfg_rd = {cfg_q[31:2], rx_sync, cfg_q[CFG_TXLVL]};

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out_o <= 1'b0;
      pad_oe_o  <= 1'b0;
    end else begin
      pad_out_o <= gpio & cfg_q[CFG_TXLVL];
      pad_oe_o  <= gpio & ~cfg_q[CFG_TXDIS];
    end
  end
endmodule

// File: rtl/padgrp_evt_ctrl.sv
module padgrp_evt_ctrl
  import padgrp_pkg::*;
#(
  parameter int NPADS  = 24,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_we,
  output logic [31:0]       reg_rdata,
  input  logic [NPADS-1:0]  pad_in,
  output logic [NPADS-1:0]  pad_out,
  output logic [NPADS-1:0]  pad_oe,
  output logic              irq_o,
  output logic              wake_o
);
  localparam logic [ADDR_W-1:0] A_INT_STS = ADDR_W'(ADR_INT_STS);
  localparam logic [ADDR_W-1:0] A_INT_EN  = ADDR_W'(ADR_INT_EN);
  localparam logic [ADDR_W-1:0] A_WK_STS  = ADDR_W'(ADR_WK_STS);
  localparam logic [ADDR_W-1:0] A_WK_EN   = ADDR_W'(ADR_WK_EN);

  logic [NPADS-1:0]       rx_sync;
  logic [NPADS-1:0]       evt_vec, sci_vec, gpio_vec;
  logic [NPADS-1:0][31:0] cfg_vec;
  logic [NPADS-1:0]       int_sts, wk_sts;
  logic [NPADS-1:0]       int_en_q, wk_en_q;
  logic [31:0]            rd_mux;

  padgrp_sync #(.W(NPADS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pad_in),
    .q_o (rx_sync)
  );

  for (genvar i = 0; i < NPADS; i++) begin : g_pad
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(ADR_CFG + CFG_PITCH * i);
    padgrp_pad u_pad (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (reg_we && (reg_addr == A_CFG)),
      .wdata     (reg_wdata),
      .rx_sync   (rx_sync[i]),
      .cfg_rd    (cfg_vec[i]),
      .evt_o     (evt_vec[i]),
      .sci_o     (sci_vec[i]),
      .gpio_o    (gpio_vec[i]),
      .pad_out_o (pad_out[i]),
      .pad_oe_o  (pad_oe[i])
    );
  end

  padgrp_w1c #(.W(NPADS)) u_int_sts (
    .clk      (clk),
    .rst      (rst),
    .clr_we   (reg_we && (reg_addr == A_INT_STS)),
    .clr_bits (reg_wdata[NPADS-1:0]),
    .set_bits (evt_vec),
    .sts_o    (int_sts)
  );

  padgrp_w1c #(.W(NPADS)) u_wk_sts (
    .clk      (clk),
    .rst      (rst),
    .clr_we   (reg_we && (reg_addr == A_WK_STS)),
    .clr_bits (reg_wdata[NPADS-1:0]),
    .set_bits (evt_vec),
    .sts_o    (wk_sts)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_en_q <= '0;
      wk_en_q  <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_INT_EN) int_en_q <= reg_wdata[NPADS-1:0];
      if (reg_addr == A_WK_EN)  wk_en_q  <= reg_wdata[NPADS-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      A_INT_STS: rd_mux = 32'(int_sts);
      A_INT_EN:  rd_mux = 32'(int_en_q);
      A_WK_STS:  rd_mux = 32'(wk_sts);
      A_WK_EN:   rd_mux = 32'(wk_en_q);
      default: begin
        for (int i = 0; i < NPADS; i++) begin
          if (reg_addr == ADDR_W'(ADR_CFG + CFG_PITCH * i)) rd_mux = cfg_vec[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
      wake_o    <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      irq_o     <= |(int_sts & int_en_q);
      wake_o    <= |(wk_sts & wk_en_q & ~sci_vec);
    end
  end
endmodule

// File: rtl/padgrp_evt_ctrl_chk.sv
module padgrp_evt_ctrl_chk #(
  parameter int NPADS = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_o,
  input logic             wake_o,
  input logic [NPADS-1:0] pad_oe,
  input logic [NPADS-1:0] evt_vec,
  input logic [NPADS-1:0] sci_vec,
  input logic [NPADS-1:0] gpio_vec,
  input logic [NPADS-1:0] int_sts,
  input logic [NPADS-1:0] int_en_q,
  input logic [NPADS-1:0] wk_sts,
  input logic [NPADS-1:0] wk_en_q
);
  // R9: an event always leaves its status bit set next cycle
  p_event_wins_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((int_sts & $past(evt_vec)) == $past(evt_vec)));

  // R8: a status bit never appears without an event
  p_no_spurious_set_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((int_sts & ~$past(int_sts) & ~$past(evt_vec)) == '0));

  // R10: interrupt rises only after an enabled status bit existed
  p_irq_source_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past((int_sts & int_en_q) != '0));

  // R11: wake rises only from an enabled pad not routed to SCI
  p_wake_source_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_o) |-> $past((wk_sts & wk_en_q & ~sci_vec) != '0));

  // R3: output enable only for pads in GPIO mode
  p_oe_gpio_only_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & ~$past(gpio_vec)) == '0));
endmodule

bind padgrp_evt_ctrl padgrp_evt_ctrl_chk #(.NPADS(NPADS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_o    (irq_o),
  .wake_o   (wake_o),
  .pad_oe   (pad_oe),
  .evt_vec  (evt_vec),
  .sci_vec  (sci_vec),
  .gpio_vec (gpio_vec),
  .int_sts  (int_sts),
  .int_en_q (int_en_q),
  .wk_sts   (wk_sts),
  .wk_en_q  (wk_en_q)
);

// File: tb/test_padgrp_evt_ctrl.sv
module test_padgrp_evt_ctrl;
  localparam int NPADS = 24;
  localparam int AW    = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [AW-1:0]    reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic             reg_we = 1'b0;
  logic [31:0]      reg_rdata;
  logic [NPADS-1:0] pad_in = '0;
  logic [NPADS-1:0] pad_out, pad_oe;
  logic             irq_o, wake_o;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  padgrp_evt_ctrl #(.NPADS(NPADS), .ADDR_W(AW)) i_padgrp_evt_ctrl (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_o(irq_o), .wake_o(wake_o)
  );

  localparam logic [AW-1:0] STS = 12'h100, IEN = 12'h120, WSTS = 12'h140, WEN = 12'h160;
  function automatic logic [AW-1:0] cfga(int i);
    return AW'(12'h400 + 8 * i);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_reg(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    check(v === exp, tag, v, exp);
  endtask

  task automatic t_reset;
    expect_reg(cfga(0), 32'h300, "R1 cfg0 reset");
    expect_reg(cfga(23), 32'h300, "R1 cfg23 reset");
    expect_reg(STS, 0, "R1 int status reset");
    expect_reg(IEN, 0, "R1 int enable reset");
    expect_reg(WSTS, 0, "R1 wake status reset");
    expect_reg(WEN, 0, "R1 wake enable reset");
    check(pad_oe === '0 && pad_out === '0, "R1 pad outputs reset", 32'(pad_oe), 0);
    check(irq_o === 1'b0 && wake_o === 1'b0, "R1 irq/wake reset", {30'd0, irq_o, wake_o}, 0);
  endtask

  task automatic t_cfg;
    wr(cfga(5), 32'hFFFF_FFFF);
    expect_reg(cfga(5), 32'h069E_3F01, "R2 writable mask");
    pad_in[5] = 1'b1;
    settle(4);
    expect_reg(cfga(5), 32'h069E_3F03, "R2 rx state bit");
    check(pad_oe[5] === 1'b0, "R3 oe off in non-GPIO mode", 32'(pad_oe[5]), 0);
    pad_in[5] = 1'b0;
    wr(cfga(5), 32'h300);
    settle(4);
    wr(STS, 32'hFFFF_FFFF);
    wr(WSTS, 32'hFFFF_FFFF);
  endtask

  task automatic t_output;
    wr(cfga(3), 32'h0000_0201);
    settle(2);
    check(pad_oe[3] === 1'b1, "R3 oe in GPIO mode", 32'(pad_oe[3]), 1);
    check(pad_out[3] === 1'b1, "R3 out level", 32'(pad_out[3]), 1);
    wr(cfga(3), 32'h0000_0601);
    settle(2);
    check(pad_oe[3] === 1'b0 && pad_out[3] === 1'b0, "R3 outputs off in mode 1",
          {30'd0, pad_oe[3], pad_out[3]}, 0);
    wr(cfga(3), 32'h300);
  endtask

  task automatic t_level;
    wr(cfga(2), 32'h0);
    pad_in[2] = 1'b1;
    settle(6);
    expect_reg(STS, 32'h4, "R4 level sets status");
    check(irq_o === 1'b0, "R10 irq held off while disabled", 32'(irq_o), 0);
    wr(IEN, 32'h4);
    settle(3);
    check(irq_o === 1'b1, "R10 irq with enable", 32'(irq_o), 1);
    wr(STS, 32'h4);
    expect_reg(STS, 32'h4, "R9 clear loses to active level");
    pad_in[2] = 1'b0;
    settle(6);
    wr(STS, 32'h4);
    expect_reg(STS, 32'h0, "R8 clear after level drops");
    settle(2);
    check(irq_o === 1'b0, "R10 irq drops", 32'(irq_o), 0);
    wr(cfga(2), 32'h0080_0000);
    settle(3);
    expect_reg(STS, 32'h4, "R4 inverted level on low input");
    wr(cfga(2), 32'h300);
    wr(IEN, 32'h0);
    wr(STS, 32'h4);
    wr(WSTS, 32'hFFFF_FFFF);
    expect_reg(STS, 32'h0, "R7 receive-disabled pad stays quiet");
  endtask

  task automatic t_edge;
    wr(cfga(7), 32'h0200_0000);
    pad_in[7] = 1'b1;
    settle(6);
    expect_reg(STS, 32'h80, "R5 rising edge");
    wr(STS, 32'h80);
    settle(3);
    expect_reg(STS, 32'h0, "R5 steady high no re-trigger");
    pad_in[7] = 1'b0;
    settle(6);
    expect_reg(STS, 32'h0, "R5 falling ignored");
    wr(cfga(7), 32'h0280_0000);
    settle(3);
    expect_reg(STS, 32'h0, "R5 inversion change no event");
    pad_in[7] = 1'b1;
    settle(6);
    expect_reg(STS, 32'h0, "R5 inverted rising ignored");
    pad_in[7] = 1'b0;
    settle(6);
    expect_reg(STS, 32'h80, "R5 inverted falling");
    wr(STS, 32'h80);
    wr(WSTS, 32'hFFFF_FFFF);
  endtask

  task automatic t_both;
    wr(cfga(9), 32'h0600_0000);
    pad_in[9] = 1'b1;
    settle(6);
    expect_reg(STS, 32'h200, "R6 both: rising");
    wr(STS, 32'h200);
    pad_in[9] = 1'b0;
    settle(6);
    expect_reg(STS, 32'h200, "R6 both: falling");
    wr(STS, 32'h200);
    wr(WSTS, 32'hFFFF_FFFF);
  endtask

  task automatic t_disabled;
    wr(cfga(11), 32'h0400_0000);
    pad_in[11] = 1'b1; settle(6);
    pad_in[11] = 1'b0; settle(6);
    expect_reg(STS, 32'h0, "R7 event select off");
    wr(cfga(11), 32'h0000_0200);
    pad_in[11] = 1'b1; settle(6);
    expect_reg(STS, 32'h0, "R7 receive disabled");
    wr(cfga(11), 32'h0000_0400);
    settle(4);
    expect_reg(STS, 32'h0, "R7 non-GPIO mode");
    pad_in[11] = 1'b0;
    wr(cfga(11), 32'h300);
    settle(4);
    expect_reg(WSTS, 32'h0, "R7 no wake status either");
  endtask

  task automatic t_w1c;
    wr(cfga(7), 32'h0200_0000);
    wr(cfga(9), 32'h0200_0000);
    pad_in[7] = 1'b1; pad_in[9] = 1'b1;
    settle(6);
    expect_reg(STS, 32'h280, "R8 two bits set");
    wr(STS, 32'h0);
    expect_reg(STS, 32'h280, "R8 writing zero keeps bits");
    wr(STS, 32'h80);
    expect_reg(STS, 32'h200, "R8 selective clear");
    wr(STS, 32'h200);
    expect_reg(WSTS, 32'h280, "R11 wake status set by events");
    wr(WSTS, 32'h80);
    expect_reg(WSTS, 32'h200, "R8 wake status selective clear");
    wr(WSTS, 32'h200);
    wr(cfga(7), 32'h300);
    wr(cfga(9), 32'h300);
    pad_in[7] = 1'b0; pad_in[9] = 1'b0;
    settle(4);
  endtask

  task automatic t_wake;
    wr(cfga(13), 32'h0200_0000);
    wr(WEN, 32'h2000);
    pad_in[13] = 1'b1;
    settle(6);
    check(wake_o === 1'b1, "R11 wake asserts", 32'(wake_o), 1);
    wr(cfga(13), 32'h0208_0000);
    settle(3);
    check(wake_o === 1'b0, "R11 SCI routing blocks wake", 32'(wake_o), 0);
    wr(cfga(13), 32'h0200_0000);
    settle(3);
    check(wake_o === 1'b1, "R11 wake returns", 32'(wake_o), 1);
    wr(WSTS, 32'h2000);
    settle(3);
    check(wake_o === 1'b0, "R11 wake cleared", 32'(wake_o), 0);
    check(irq_o === 1'b0, "R10 no irq without enable", 32'(irq_o), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_output();
    t_level();
    t_edge();
    t_both();
    t_disabled();
    t_w1c();
    t_wake();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog (all requirements) act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule